// File: doc/BRIEF.md
# Shared-Interval Input Deglitch Filter Bank

This block cleans up a bank of digital inputs, 24 channels by default, before they reach the rest of the chip. A single programmable qualification window is shared by every channel. A channel whose enable bit is set shows a new level only after its raw input has differed from the shown level and then held still for at least one full window. A channel whose bit is clear passes the registered raw input straight through. The window length is a count of base ticks, and a prescaler derives each tick from the system clock.

Software reaches the block through a byte-wide write port. The window length is written as three bytes into a staging register. That value has no effect until software writes a reload command to a control byte. A second command bit on the same control byte drops every pending qualification and snaps each filtered output to its current raw level. The filtered levels can be read back one byte at a time over a small select input. The registered raw levels are also brought out in full.

Top module: `dgl_filter_bank`

## Requirements
- R1: After reset the enable mask, the staged interval and the active interval are all zero, and `filt_o`, `raw_o` and `rd_byte` read zero.
- R2: Write addresses: 0, 1 and 2 hold the interval bits [7:0], [15:8] and [19:16]. Only the low 4 bits of the byte written to address 2 are kept. Address 3 is the control byte: bit 0 reloads the interval and bit 1 flushes the filters. Addresses 4, 5 and 6 hold the enable bits for channels 0–7, 8–15 and 16–23.
- R3: Writing the interval bytes changes nothing until a reload command is written. From that command on, the new interval governs every channel.
- R4: A channel whose enable bit is 0 shows its raw input on `filt_o` one clock after it appears on `raw_i`.
- R5: An enabled channel keeps its old level for at least interval×TICK_DIV clocks after a raw change. It takes the new level no later than 2×interval×TICK_DIV+2 clocks after that change, provided the input holds.
- R6: A pulse on an enabled channel that is shorter than interval×TICK_DIV clocks never reaches `filt_o`. Any change during qualification restarts the channel's qualification.
- R7: While the active interval is zero, every channel behaves as unfiltered, as in R4.
- R8: A flush command sets every filtered output to the raw level held on the clock of the command and cancels pending qualifications.
- R9: `rd_byte` returns the filtered channels 0–7, 8–15 and 16–23 for `rd_sel` 0, 1 and 2, and zero for `rd_sel` 3.
- R10: Window boundaries are `interval` ticks apart, ticks are TICK_DIV clocks apart, and an enabled channel's output changes only at a boundary or on a flush.
- R11: `raw_o` equals `raw_i` delayed by one clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register write address |
| wr_data | input | 8 | Register write data |
| raw_i | input | NUM_CH | Unfiltered channel inputs |
| rd_sel | input | 2 | Byte lane select for filtered readback |
| filt_o | output | NUM_CH | Filtered channel levels |
| raw_o | output | NUM_CH | Registered raw channel levels |
| rd_byte | output | 8 | Selected byte of filtered levels |

## Verification
Several properties are checked on every cycle: tick spacing, the window counter staying below the active interval, and the active interval moving only on a reload. A bypassed channel must track the raw input one clock later. An enabled channel may change only at a window boundary or on a flush, and a flush must copy the held raw level. The stimulus scenarios show the rest. These are the lower and upper latency bounds of a qualified step, the rejection of short pulses and bounce trains, the staging of the interval bytes with the masked upper nibble, per-byte enable, and the readback lanes.

// File: rtl/dgl_pkg.sv
package dgl_pkg;

    localparam int BYTE_W = 8;
    localparam int ADDR_W = 4;

    // write address map
    localparam logic [ADDR_W-1:0] ADR_IVAL_BASE = 4'd0;
    localparam logic [ADDR_W-1:0] ADR_CTRL      = 4'd3;
    localparam logic [ADDR_W-1:0] ADR_ENA_BASE  = 4'd4;

    // control byte bit positions
    localparam int CTRL_RELOAD_BIT = 0;
    localparam int CTRL_FLUSH_BIT  = 1;

    typedef struct packed {
        logic reload;
        logic flush;
    } ctrl_cmd_t;

    typedef struct packed {
        logic tick;
        logic win_end;
    } timebase_t;

    typedef struct packed {
        logic level;
        logic armed;
        logic prev;
    } chan_state_t;

    function automatic int bytes_for(input int bits);
        return (bits + BYTE_W - 1) / BYTE_W;
    endfunction

    function automatic int width_for(input int count);
        return (count > 1) ? $clog2(count) : 1;
    endfunction

endpackage

// File: rtl/dgl_regs.sv
module dgl_regs
    import dgl_pkg::*;
#(
    parameter int NUM_CH = 24,
    parameter int IVAL_W = 20
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wr_en,
    input  logic [ADDR_W-1:0]    wr_addr,
    input  logic [BYTE_W-1:0]    wr_data,
    output logic [IVAL_W-1:0]    ival_stage,
    output logic [NUM_CH-1:0]    ena,
    output ctrl_cmd_t            cmd
);

    // staged interval, one flop per bit, byte lane picked by bit index
    for (genvar b = 0; b < IVAL_W; b++) begin : g_ival_bit
        localparam logic [ADDR_W-1:0] LANE_ADR = ADR_IVAL_BASE + ADDR_W'(b / BYTE_W);
        always_ff @(posedge clk) begin
            if (rst)
                ival_stage[b] <= 1'b0;
            else if (wr_en && (wr_addr == LANE_ADR))
                ival_stage[b] <= wr_data[b % BYTE_W];
        end
    end

    // channel enable mask
    for (genvar c = 0; c < NUM_CH; c++) begin : g_ena_bit
        localparam logic [ADDR_W-1:0] LANE_ADR = ADR_ENA_BASE + ADDR_W'(c / BYTE_W);
        always_ff @(posedge clk) begin
            if (rst)
                ena[c] <= 1'b0;
            else if (wr_en && (wr_addr == LANE_ADR))
                ena[c] <= wr_data[c % BYTE_W];
        end
    end

    // command strobes act on the edge that accepts the write
    always_comb begin
        cmd.reload = wr_en && (wr_addr == ADR_CTRL) && wr_data[CTRL_RELOAD_BIT];
        cmd.flush  = wr_en && (wr_addr == ADR_CTRL) && wr_data[CTRL_FLUSH_BIT];
    end

endmodule

// File: rtl/dgl_timebase.sv
module dgl_timebase
    import dgl_pkg::*;
#(
    parameter int TICK_DIV = 20,
    parameter int IVAL_W   = 20
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reload,
    input  logic [IVAL_W-1:0] ival_stage,
    output logic [IVAL_W-1:0] ival_act,
    output logic [IVAL_W-1:0] win_cnt,
    output timebase_t         tb
);

    localparam int PW = width_for(TICK_DIV);

    logic tick;
    logic last_tick;

    // base tick prescaler
    if (TICK_DIV > 1) begin : g_presc
        logic [PW-1:0] presc;
        assign tick = (presc == PW'(TICK_DIV - 1));
        always_ff @(posedge clk) begin
            if (rst || reload)
                presc <= '0;
            else if (tick)
                presc <= '0;
            else
                presc <= presc + 1'b1;
        end
    end else begin : g_no_presc
        assign tick = 1'b1;
    end

    // active interval, loaded only by the reload command
    always_ff @(posedge clk) begin
        if (rst)
            ival_act <= '0;
        else if (reload)
            ival_act <= ival_stage;
    end

    // shared window counter
    assign last_tick = (win_cnt == (ival_act - 1'b1));

    always_ff @(posedge clk) begin
        if (rst || reload)
            win_cnt <= '0;
        else if (ival_act == '0)
            win_cnt <= '0;
        else if (tick)
            win_cnt <= last_tick ? '0 : win_cnt + 1'b1;
    end

    always_comb begin
        tb.tick    = tick;
        tb.win_end = tick && last_tick && (ival_act != '0) && !reload;
    end

endmodule

// File: rtl/dgl_chan.sv
module dgl_chan
    import dgl_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic raw,
    input  logic bypass,
    input  logic flush,
    input  logic win_end,
    output logic level_o
);

    chan_state_t st;

    always_ff @(posedge clk) begin
        if (rst) begin
            st <= '0;
        end else begin
            st.prev <= raw;
            if (bypass || flush) begin
                st.level <= raw;
                st.armed <= 1'b0;
            end else if (raw != st.prev) begin
                // bounce: qualification starts over
                st.armed <= 1'b0;
            end else if (win_end) begin
                if (st.armed) begin
                    st.level <= raw;
                    st.armed <= 1'b0;
                end else begin
                    st.armed <= (raw != st.level);
                end
            end
        end
    end

    assign level_o = bypass ? raw : st.level;

endmodule

// File: rtl/dgl_filter_bank.sv
module dgl_filter_bank
    import dgl_pkg::*;
#(
    parameter int NUM_CH   = 24,
    parameter int IVAL_W   = 20,
    parameter int TICK_DIV = 20
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [3:0]        wr_addr,
    input  logic [7:0]        wr_data,
    input  logic [NUM_CH-1:0] raw_i,
    input  logic [1:0]        rd_sel,
    output logic [NUM_CH-1:0] filt_o,
    output logic [NUM_CH-1:0] raw_o,
    output logic [7:0]        rd_byte
);

    localparam int NBYTES = bytes_for(NUM_CH);

    logic [IVAL_W-1:0] ival_stage;
    logic [IVAL_W-1:0] ival_act;
    logic [IVAL_W-1:0] win_cnt;
    logic [NUM_CH-1:0] ena;
    logic [NUM_CH-1:0] raw_q;
    ctrl_cmd_t         cmd;
    timebase_t         tb;
    logic              tick;
    logic              win_end;
    logic              reload;
    logic              flush;
    logic              all_bypass;

    dgl_regs #(
        .NUM_CH (NUM_CH),
        .IVAL_W (IVAL_W)
    ) u_regs (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .ival_stage (ival_stage),
        .ena        (ena),
        .cmd        (cmd)
    );

    assign reload = cmd.reload;
    assign flush  = cmd.flush;

    dgl_timebase #(
        .TICK_DIV (TICK_DIV),
        .IVAL_W   (IVAL_W)
    ) u_tb (
        .clk        (clk),
        .rst        (rst),
        .reload     (reload),
        .ival_stage (ival_stage),
        .ival_act   (ival_act),
        .win_cnt    (win_cnt),
        .tb         (tb)
    );

    assign tick       = tb.tick;
    assign win_end    = tb.win_end;
    assign all_bypass = (ival_act == '0);

    always_ff @(posedge clk) begin
        if (rst)
            raw_q <= '0;
        else
            raw_q <= raw_i;
    end

    for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
        dgl_chan u_chan (
            .clk     (clk),
            .rst     (rst),
            .raw     (raw_q[c]),
            .bypass  (all_bypass || !ena[c]),
            .flush   (flush),
            .win_end (win_end),
            .level_o (filt_o[c])
        );
    end

    assign raw_o = raw_q;

    // byte lane readback, lanes past the last channel read zero
    always_comb begin
        rd_byte = '0;
        for (int k = 0; k < BYTE_W; k++) begin
            if ((int'(rd_sel) < NBYTES) && (int'(rd_sel) * BYTE_W + k < NUM_CH))
                rd_byte[k] = filt_o[int'(rd_sel) * BYTE_W + k];
        end
    end

endmodule

// File: rtl/dgl_filter_bank_chk.sv
module dgl_filter_bank_chk #(
    parameter int NUM_CH   = 24,
    parameter int IVAL_W   = 20,
    parameter int TICK_DIV = 20
) (
    input logic              clk,
    input logic              rst,
    input logic [NUM_CH-1:0] raw_i,
    input logic [NUM_CH-1:0] filt_o,
    input logic [NUM_CH-1:0] raw_o,
    input logic [NUM_CH-1:0] ena,
    input logic [IVAL_W-1:0] ival_act,
    input logic [IVAL_W-1:0] win_cnt,
    input logic              tick,
    input logic              win_end,
    input logic              reload,
    input logic              flush
);

    if (TICK_DIV > 1) begin : g_tick_chk
        assert_tick_spacing_R10: assert property (@(posedge clk) disable iff (rst)
            tick |=> !tick);
    end

    assert_window_bound_R10: assert property (@(posedge clk) disable iff (rst)
        (ival_act != '0) |-> (win_cnt < ival_act));

    assert_interval_hold_R3: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(reload)) |-> (ival_act == $past(ival_act)));

    assert_raw_delay_R11: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (raw_o == $past(raw_i)));

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch_chk
        assert_bypass_follow_R4: assert property (@(posedge clk) disable iff (rst)
            (!$past(rst) && (!ena[c] || ival_act == '0)) |-> (filt_o[c] == $past(raw_i[c])));

        assert_edge_only_R10: assert property (@(posedge clk) disable iff (rst)
            (ena[c] && ival_act != '0 &&
             $past(ena[c] && ival_act != '0 && !win_end && !flush && !reload))
            |-> (filt_o[c] == $past(filt_o[c])));

        assert_flush_copy_R8: assert property (@(posedge clk) disable iff (rst)
            (!$past(rst) && ena[c] && ival_act != '0 &&
             $past(flush && ena[c] && ival_act != '0 && !reload))
            |-> (filt_o[c] == $past(raw_o[c])));
    end

endmodule

bind dgl_filter_bank dgl_filter_bank_chk #(
    .NUM_CH   (NUM_CH),
    .IVAL_W   (IVAL_W),
    .TICK_DIV (TICK_DIV)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .raw_i    (raw_i),
    .filt_o   (filt_o),
    .raw_o    (raw_o),
    .ena      (ena),
    .ival_act (ival_act),
    .win_cnt  (win_cnt),
    .tick     (tick),
    .win_end  (win_end),
    .reload   (reload),
    .flush    (flush)
);

// File: tb/dgl_filter_bank_tb.sv
module dgl_filter_bank_tb;

    localparam int CLK_NS = 10;
    localparam int NCH    = 24;
    localparam int DIV    = 3;

    logic           clk = 1'b0;
    logic           rst;
    logic           wr_en;
    logic [3:0]     wr_addr;
    logic [7:0]     wr_data;
    logic [NCH-1:0] raw_i;
    logic [1:0]     rd_sel;
    logic [NCH-1:0] filt_o;
    logic [NCH-1:0] raw_o;
    logic [7:0]     rd_byte;

    int n_run  = 0;
    int n_fail = 0;

    dgl_filter_bank #(
        .NUM_CH   (NCH),
        .IVAL_W   (20),
        .TICK_DIV (DIV)
    ) u_dut (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .raw_i   (raw_i),
        .rd_sel  (rd_sel),
        .filt_o  (filt_o),
        .raw_o   (raw_o),
        .rd_byte (rd_byte)
    );

    always #(CLK_NS / 2) clk = ~clk;

    task automatic summary();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    endtask

    task automatic chk(input string req, input logic [NCH-1:0] act, input logic [NCH-1:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        wr_en   = 1'b1;
        wr_addr = a;
        wr_data = d;
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    // stage interval with junk in the ignored upper nibble, then reload
    task automatic set_interval(input int v);
        wr(4'd0, 8'(v));
        wr(4'd1, 8'(v >> 8));
        wr(4'd2, {4'h5, 4'(v >> 16)});
        wr(4'd3, 8'h01);
    endtask

    function automatic logic [NCH-1:0] rnd_mask();
        return NCH'($urandom) | NCH'(1);
    endfunction

    // step a set of filtered channels and check both latency bounds
    task automatic step_check(input logic [NCH-1:0] m, input int w, input string req);
        logic [NCH-1:0] old_v;
        logic [NCH-1:0] new_v;
        old_v = filt_o;
        raw_i = raw_i ^ m;
        new_v = raw_i;
        for (int k = 0; k < w; k++) begin
            cyc(1);
            chk({req, " hold"}, filt_o, old_v);
        end
        cyc(w + 4);
        chk({req, " pass"}, filt_o, new_v);
    endtask

    initial begin
        cyc(150000);
        n_run++;
        n_fail++;
        $display("FAIL watchdog act=timeout exp=finished");
        summary();
    end

    initial begin
        logic [NCH-1:0] m;
        logic [NCH-1:0] old_v;
        int w;
        int len;
        void'($urandom(32'd2718));
        rst = 1'b1; wr_en = 1'b0; wr_addr = '0; wr_data = '0; raw_i = '0; rd_sel = '0;
        cyc(4);
        rst = 1'b0;
        cyc(1);

        // R1 reset state
        chk("R1 filt", filt_o, '0);
        chk("R1 raw", raw_o, '0);
        chk("R1 rd_byte", NCH'(rd_byte), '0);

        // R4 / R1 unfiltered after reset, R11 raw delay
        for (int i = 0; i < 6; i++) begin
            m = NCH'($urandom);
            raw_i = m;
            cyc(1);
            chk("R4 bypass after reset", filt_o, m);
            chk("R11 raw delay", raw_o, m);
        end

        // R9 readback lanes
        raw_i = 24'hA5C30F;
        cyc(1);
        for (int s = 0; s < 4; s++) begin
            rd_sel = 2'(s);
            #1;
            chk("R9 lane", NCH'(rd_byte), (s == 0) ? 24'h0F : (s == 1) ? 24'hC3 : (s == 2) ? 24'hA5 : 24'h0);
        end
        rd_sel = 2'd0;

        // R2 / R7 upper nibble of byte 2 ignored -> interval zero -> bypass
        wr(4'd4, 8'hFF); wr(4'd5, 8'hFF); wr(4'd6, 8'hFF);
        wr(4'd0, 8'h00); wr(4'd1, 8'h00); wr(4'd2, 8'hF0); wr(4'd3, 8'h01);
        for (int i = 0; i < 3; i++) begin
            m = NCH'($urandom);
            raw_i = m;
            cyc(1);
            chk("R7 zero interval bypass (R2 nibble)", filt_o, m);
        end

        // R5 filtered steps, interval 4
        set_interval(4);
        w = 4 * DIV;
        cyc(2 * w + 4);
        chk("R8 settled", filt_o, raw_i);
        for (int i = 0; i < 6; i++) begin
            step_check(rnd_mask(), w, "R5 step");
        end

        // R6 short pulses never pass
        for (int i = 0; i < 6; i++) begin
            m = rnd_mask();
            old_v = filt_o;
            len = 1 + int'($urandom % (w - 1));
            raw_i = raw_i ^ m;
            for (int k = 0; k < len; k++) begin
                cyc(1);
                chk("R6 pulse", filt_o, old_v);
            end
            raw_i = raw_i ^ m;
            for (int k = 0; k < 3 * w; k++) begin
                cyc(1);
                chk("R6 pulse after", filt_o, old_v);
            end
        end

        // R6 bounce train restarts qualification
        for (int i = 0; i < 3; i++) begin
            m = rnd_mask();
            old_v = filt_o;
            raw_i = raw_i ^ m;
            cyc(w - 5);
            raw_i = raw_i ^ m;
            cyc(8);
            chk("R6 bounce", filt_o, old_v);
            step_check(m, w, "R6 restart");
        end

        // R8 flush mid qualification
        m = rnd_mask();
        raw_i = raw_i ^ m;
        cyc(3);
        wr(4'd3, 8'h02);
        chk("R8 flush", filt_o, raw_i);
        cyc(2 * w + 4);

        // R4 / R2 per-byte enable: lane 1 unfiltered
        wr(4'd5, 8'h00);
        old_v = filt_o;
        m = 24'hFFFFFF;
        raw_i = raw_i ^ m;
        cyc(1);
        chk("R4 partial enable", filt_o, (old_v & 24'hFF00FF) | (raw_i & 24'h00FF00));
        cyc(2 * w + 3);
        chk("R4 partial enable settle", filt_o, raw_i);
        wr(4'd6, 8'h00);
        m = rnd_mask() | 24'hFF0000;
        old_v = filt_o;
        raw_i = raw_i ^ m;
        cyc(1);
        chk("R2 lane 2 enable", filt_o, (old_v & 24'h0000FF) | (raw_i & 24'hFFFF00));
        wr(4'd5, 8'hFF);
        wr(4'd6, 8'hFF);
        cyc(2 * w + 4);

        // R3 staged interval inert until reload
        wr(4'd0, 8'd10); wr(4'd1, 8'd0); wr(4'd2, 8'd0);
        step_check(rnd_mask(), w, "R3 before reload");
        wr(4'd3, 8'h01);
        cyc(2 * 10 * DIV + 4);
        step_check(rnd_mask(), 10 * DIV, "R3 after reload");

        // R5 random intervals
        for (int i = 0; i < 8; i++) begin
            int iv;
            iv = 1 + int'($urandom % 6);
            set_interval(iv);
            cyc(2 * iv * DIV + 4);
            step_check(rnd_mask(), iv * DIV, "R5 random");
        end

        // R7 back to zero interval
        set_interval(0);
        m = NCH'($urandom);
        raw_i = m;
        cyc(1);
        chk("R7 zero interval", filt_o, m);

        summary();
    end

endmodule